// File: doc/BRIEF.md
# Lockable Fully Associative Translation Cache

This block keeps a small set of recently resolved virtual-to-physical translations so that most memory accesses never need a page-table walk. Every entry holds a virtual page tag, a physical base, a page-size code, a domain number, access-permission bits and cache attributes. A lookup compares the incoming virtual address against all valid entries at once. Hit, physical address and attributes come back in the same cycle. Translations can come from single-level section walks or from two-level page walks, so entries of 1 MB, 64 KB, 4 KB and 1 KB pages live side by side.

On a miss, the walker writes the resolved translation through a refill port. A round-robin pointer picks the slot to replace. Entries whose index lies below a programmable lock base are pinned: replacement, global flush and invalidate-by-address all leave them alone. Translations that must survive a task switch therefore stay resident, while everything else can be discarded in one cycle. The walk itself and permission enforcement belong to other blocks.

Top module: `tlb_lockdown`

## Requirements
- R1: After reset every entry is invalid, the lock base is 0 and the replacement pointer is at entry 0. Every lookup misses and fill_bypass_o is 0.
- R2: A lookup is combinational. lk_hit_o is 1 only while lk_valid_i is 1 and a valid entry covers lk_va_i. On a hit, lk_pa_o is the stored physical base above the page offset joined with lk_va_i below it. lk_dom_o, lk_ap_o and lk_attr_o return the stored fields.
- R3: The page-size code is 0 = 1 KB, 1 = 4 KB, 2 = 64 KB and 3 = 1 MB. An entry covers exactly the aligned page of its size that contains its virtual address.
- R4: A refill that overlaps no entry is written to the slot under the round-robin pointer. The pointer then advances by one, and past the last entry it wraps to the lock base rather than to 0.
- R5: Two translations overlap when they fall in the same page of the coarser of their two sizes. A refill that overlaps an unlocked entry overwrites the lowest-indexed such entry and leaves the pointer unchanged, so no duplicate is created.
- R6: Entries with an index below the lock base (loaded through lock_we_i, range 0 to ENTRIES) are locked. They are never chosen as a victim, never overwritten, and not cleared by flush or invalidate.
- R7: A flush clears every unlocked entry in one cycle.
- R8: An invalidate clears every unlocked entry whose page contains inval_va_i.
- R9: When every entry is locked, a refill that overlaps nothing is dropped and fill_bypass_o is 1 in that cycle. A refill that overlaps a locked entry is dropped with fill_bypass_o at 0.
- R10: When a refill coincides with a flush or an invalidate, the clearing acts on the old contents first and the refilled translation is valid afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lk_valid_i | input | 1 | Lookup request |
| lk_va_i | input | VA_W | Lookup virtual address |
| lk_hit_o | output | 1 | Lookup hit |
| lk_pa_o | output | PA_W | Translated physical address |
| lk_size_o | output | 2 | Page-size code of the hitting entry |
| lk_dom_o | output | DOM_W | Domain of the hitting entry |
| lk_ap_o | output | AP_W | Access-permission bits of the hitting entry |
| lk_attr_o | output | ATTR_W | Cache attributes of the hitting entry |
| fill_valid_i | input | 1 | Refill request from the walker |
| fill_va_i | input | VA_W | Refill virtual address |
| fill_pa_i | input | PA_W | Refill physical base |
| fill_size_i | input | 2 | Refill page-size code |
| fill_dom_i | input | DOM_W | Refill domain |
| fill_ap_i | input | AP_W | Refill access-permission bits |
| fill_attr_i | input | ATTR_W | Refill cache attributes |
| fill_bypass_o | output | 1 | Refill dropped because all entries are locked |
| flush_i | input | 1 | Clear all unlocked entries |
| inval_i | input | 1 | Invalidate by address |
| inval_va_i | input | VA_W | Address to invalidate |
| lock_we_i | input | 1 | Load the lock base |
| lock_base_i | input | CNT_W | New lock base |

## Verification
A refill can land in the same cycle as a flush or an invalidate, and the order between them decides whether the new translation survives. The bench fills two pages, then raises flush together with a refill of a third page. It also raises an invalidate of a page together with a refill of that same page under a new physical base. It judges the outcome by lookups afterwards: the refilled page must hit with its new base, and the older unlocked pages must miss.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned VA_W    = 32;
  localparam int unsigned PA_W    = 32;
  localparam int unsigned MIN_OFF = 10;
  localparam int unsigned OFF_TOP = MIN_OFF + 10;
  localparam int unsigned DOM_W   = 4;
  localparam int unsigned AP_W    = 8;
  localparam int unsigned ATTR_W  = 2;
  localparam int unsigned VPN_W   = VA_W - MIN_OFF;
  localparam int unsigned PPN_W   = PA_W - MIN_OFF;

  typedef enum logic [1:0] {
    PG_1K  = 2'd0,
    PG_4K  = 2'd1,
    PG_64K = 2'd2,
    PG_1M  = 2'd3
  } pg_size_e;

  typedef struct packed {
    logic              valid;
    logic [VPN_W-1:0]  vpn;
    logic [PPN_W-1:0]  ppn;
    pg_size_e          size;
    logic [DOM_W-1:0]  dom;
    logic [AP_W-1:0]   ap;
    logic [ATTR_W-1:0] attr;
  } tlb_ent_t;

  // page-offset bits beyond the 1 KB minimum
  function automatic int unsigned size_shift(pg_size_e s);
    case (s)
      PG_4K:   return 2;
      PG_64K:  return 6;
      PG_1M:   return 10;
      default: return 0;
    endcase
  endfunction

  function automatic logic [VPN_W-1:0] vpn_mask(pg_size_e s);
    logic [VPN_W-1:0] m;
    m = '1;
    return m << size_shift(s);
  endfunction

  function automatic logic [PA_W-1:0] off_mask(pg_size_e s);
    logic [PA_W-1:0] m;
    m = '1;
    return ~(m << (MIN_OFF + size_shift(s)));
  endfunction

  function automatic pg_size_e coarser(pg_size_e a, pg_size_e b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/tlb_entry.sv
module tlb_entry
  import tlb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             locked_i,
  input  logic             flush_i,
  input  logic             inval_i,
  input  logic [VPN_W-1:0] inval_vpn_i,
  input  logic [VPN_W-1:0] lk_vpn_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  pg_size_e         fill_size_i,
  input  logic             wr_i,
  input  tlb_ent_t         wr_ent_i,
  output logic             lk_hit_o,
  output logic             ovl_o,
  output tlb_ent_t         ent_o
);
  tlb_ent_t         ent_q;
  logic [VPN_W-1:0] own_m;
  logic [VPN_W-1:0] ovl_m;
  logic             inval_hit;

  always_comb begin
    own_m     = vpn_mask(ent_q.size);
    ovl_m     = vpn_mask(coarser(ent_q.size, fill_size_i));
    lk_hit_o  = ent_q.valid && (((lk_vpn_i ^ ent_q.vpn) & own_m) == '0);
    inval_hit = ent_q.valid && (((inval_vpn_i ^ ent_q.vpn) & own_m) == '0);
    ovl_o     = ent_q.valid && (((fill_vpn_i ^ ent_q.vpn) & ovl_m) == '0);
  end

  // refill wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_q <= '0;
    end else if (wr_i) begin
      ent_q <= wr_ent_i;
    end else if (!locked_i && (flush_i || (inval_i && inval_hit))) begin
      ent_q.valid <= 1'b0;
    end
  end

  assign ent_o = ent_q;

  // R6
  locked_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_i && !wr_i) |=> $stable(ent_q));
  // R6
  locked_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_i |-> !wr_i);
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter  int unsigned ENTRIES = 8,
  localparam int unsigned IDX_W   = $clog2(ENTRIES),
  localparam int unsigned CNT_W   = $clog2(ENTRIES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] lock_base_i,
  input  logic             adv_i,
  output logic [IDX_W-1:0] victim_o,
  output logic             full_o
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] eff;
  logic [IDX_W-1:0] nxt;

  always_comb begin
    full_o = (lock_base_i >= CNT_W'(ENTRIES));
    eff    = (CNT_W'(rr_q) < lock_base_i) ? lock_base_i[IDX_W-1:0] : rr_q;
    nxt    = (eff == IDX_W'(ENTRIES - 1)) ? lock_base_i[IDX_W-1:0] : eff + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rr_q <= '0;
    else if (adv_i) rr_q <= nxt;
  end

  assign victim_o = eff;

  // R4
  rr_in_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> (CNT_W'(rr_q) >= $past(lock_base_i)));
  // R9
  no_adv_when_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !adv_i);
endmodule

// File: rtl/tlb_lockdown.sv
module tlb_lockdown
  import tlb_pkg::*;
#(
  parameter  int unsigned ENTRIES = 8,
  localparam int unsigned IDX_W   = $clog2(ENTRIES),
  localparam int unsigned CNT_W   = $clog2(ENTRIES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_valid_i,
  input  logic [VA_W-1:0]   lk_va_i,
  output logic              lk_hit_o,
  output logic [PA_W-1:0]   lk_pa_o,
  output logic [1:0]        lk_size_o,
  output logic [DOM_W-1:0]  lk_dom_o,
  output logic [AP_W-1:0]   lk_ap_o,
  output logic [ATTR_W-1:0] lk_attr_o,
  input  logic              fill_valid_i,
  input  logic [VA_W-1:0]   fill_va_i,
  input  logic [PA_W-1:0]   fill_pa_i,
  input  logic [1:0]        fill_size_i,
  input  logic [DOM_W-1:0]  fill_dom_i,
  input  logic [AP_W-1:0]   fill_ap_i,
  input  logic [ATTR_W-1:0] fill_attr_i,
  output logic              fill_bypass_o,
  input  logic              flush_i,
  input  logic              inval_i,
  input  logic [VA_W-1:0]   inval_va_i,
  input  logic              lock_we_i,
  input  logic [CNT_W-1:0]  lock_base_i
);
  logic [CNT_W-1:0]   lock_q;
  logic [ENTRIES-1:0] hit_vec, ovl_vec, wr_vec, locked_vec, valid_vec;
  tlb_ent_t           ents [ENTRIES];
  tlb_ent_t           sel_ent, wr_ent;
  logic [IDX_W-1:0]   sel, ovl_idx, victim;
  logic               full, adv;
  pg_size_e           fsize;
  logic [PA_W-1:0]    om;

  assign fsize = pg_size_e'(fill_size_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        lock_q <= '0;
    else if (lock_we_i) lock_q <= (lock_base_i > CNT_W'(ENTRIES)) ? CNT_W'(ENTRIES) : lock_base_i;
  end

  always_comb begin
    wr_ent       = '0;
    wr_ent.valid = 1'b1;
    wr_ent.vpn   = fill_va_i[VA_W-1:MIN_OFF] & vpn_mask(fsize);
    wr_ent.ppn   = fill_pa_i[PA_W-1:MIN_OFF];
    wr_ent.size  = fsize;
    wr_ent.dom   = fill_dom_i;
    wr_ent.ap    = fill_ap_i;
    wr_ent.attr  = fill_attr_i;
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_row
    assign locked_vec[i] = (CNT_W'(i) < lock_q);
    assign valid_vec[i]  = ents[i].valid;
    tlb_entry u_row (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .locked_i    (locked_vec[i]),
      .flush_i     (flush_i),
      .inval_i     (inval_i),
      .inval_vpn_i (inval_va_i[VA_W-1:MIN_OFF]),
      .lk_vpn_i    (lk_va_i[VA_W-1:MIN_OFF]),
      .fill_vpn_i  (fill_va_i[VA_W-1:MIN_OFF]),
      .fill_size_i (fsize),
      .wr_i        (wr_vec[i]),
      .wr_ent_i    (wr_ent),
      .lk_hit_o    (hit_vec[i]),
      .ovl_o       (ovl_vec[i]),
      .ent_o       (ents[i])
    );
  end

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lock_base_i (lock_q),
    .adv_i       (adv),
    .victim_o    (victim),
    .full_o      (full)
  );

  // lowest index wins for both lookup and overlap
  always_comb begin
    sel     = '0;
    ovl_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) sel = IDX_W'(i);
      if (ovl_vec[i]) ovl_idx = IDX_W'(i);
    end
    sel_ent = ents[sel];
  end

  always_comb begin
    wr_vec        = '0;
    adv           = 1'b0;
    fill_bypass_o = 1'b0;
    if (fill_valid_i) begin
      if (|ovl_vec) begin
        if (!locked_vec[ovl_idx]) wr_vec[ovl_idx] = 1'b1;
      end else if (full) begin
        fill_bypass_o = 1'b1;
      end else begin
        wr_vec[victim] = 1'b1;
        adv            = 1'b1;
      end
    end
  end

  always_comb begin
    lk_hit_o  = lk_valid_i && (|hit_vec);
    om        = off_mask(sel_ent.size);
    lk_pa_o   = '0;
    lk_size_o = '0;
    lk_dom_o  = '0;
    lk_ap_o   = '0;
    lk_attr_o = '0;
    if (lk_hit_o) begin
      lk_pa_o   = ({sel_ent.ppn, {MIN_OFF{1'b0}}} & ~om) | (PA_W'(lk_va_i[OFF_TOP-1:0]) & om);
      lk_size_o = sel_ent.size;
      lk_dom_o  = sel_ent.dom;
      lk_ap_o   = sel_ent.ap;
      lk_attr_o = sel_ent.attr;
    end
  end

  // R2
  hit_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> lk_valid_i);
  // R7
  flush_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && !fill_valid_i) |=> ((valid_vec & ~$past(locked_vec)) == '0));
  // R9
  bypass_no_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_bypass_o && !flush_i && !inval_i) |=> $stable(valid_vec));
  // R6
  lock_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q <= CNT_W'(ENTRIES));
endmodule

// File: tb/tlb_lockdown_tb.sv
module tlb_lockdown_tb;
  import tlb_pkg::*;

  localparam int unsigned N = 4;
  localparam int unsigned CW = $clog2(N + 1);

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              lk_valid_i = 1'b0;
  logic [VA_W-1:0]   lk_va_i = '0;
  logic              lk_hit_o;
  logic [PA_W-1:0]   lk_pa_o;
  logic [1:0]        lk_size_o;
  logic [DOM_W-1:0]  lk_dom_o;
  logic [AP_W-1:0]   lk_ap_o;
  logic [ATTR_W-1:0] lk_attr_o;
  logic              fill_valid_i = 1'b0;
  logic [VA_W-1:0]   fill_va_i = '0;
  logic [PA_W-1:0]   fill_pa_i = '0;
  logic [1:0]        fill_size_i = '0;
  logic [DOM_W-1:0]  fill_dom_i = '0;
  logic [AP_W-1:0]   fill_ap_i = '0;
  logic [ATTR_W-1:0] fill_attr_i = '0;
  logic              fill_bypass_o;
  logic              flush_i = 1'b0;
  logic              inval_i = 1'b0;
  logic [VA_W-1:0]   inval_va_i = '0;
  logic              lock_we_i = 1'b0;
  logic [CW-1:0]     lock_base_i = '0;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  tlb_lockdown #(.ENTRIES(N)) u_dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] xpa(input logic [31:0] va, input logic [31:0] pa, input logic [1:0] sz);
    logic [31:0] m;
    m = (32'h1 << (10 + (sz == 2'd0 ? 0 : sz == 2'd1 ? 2 : sz == 2'd2 ? 6 : 10))) - 1;
    return (pa & ~m) | (va & m);
  endfunction

  task automatic op(input bit f, input logic [31:0] va, input logic [31:0] pa, input logic [1:0] sz,
                    input bit fl, input bit iv, input logic [31:0] iva, output bit byp);
    @(negedge clk_i);
    fill_valid_i = f;   fill_va_i = va;   fill_pa_i = pa;   fill_size_i = sz;
    fill_dom_i = va[23:20]; fill_ap_i = pa[31:24]; fill_attr_i = va[21:20];
    flush_i = fl; inval_i = iv; inval_va_i = iva;
    #2 byp = fill_bypass_o;
    @(negedge clk_i);
    fill_valid_i = 1'b0; flush_i = 1'b0; inval_i = 1'b0;
  endtask

  task automatic fill(input logic [31:0] va, input logic [31:0] pa, input logic [1:0] sz);
    bit b;
    op(1'b1, va, pa, sz, 1'b0, 1'b0, '0, b);
  endtask

  task automatic flush();
    bit b;
    op(1'b0, '0, '0, '0, 1'b1, 1'b0, '0, b);
  endtask

  task automatic inval(input logic [31:0] va);
    bit b;
    op(1'b0, '0, '0, '0, 1'b0, 1'b1, va, b);
  endtask

  task automatic set_lock(input int unsigned base);
    @(negedge clk_i);
    lock_we_i = 1'b1; lock_base_i = CW'(base);
    @(negedge clk_i);
    lock_we_i = 1'b0;
  endtask

  task automatic probe(input string req, input logic [31:0] va, input bit eh, input logic [31:0] epa);
    @(negedge clk_i);
    lk_valid_i = 1'b1; lk_va_i = va;
    #2 chk(req, 64'(lk_hit_o), 64'(eh));
    if (eh) chk(req, 64'(lk_pa_o), 64'(epa));
    lk_valid_i = 1'b0;
  endtask

  function automatic logic [31:0] pv(input int i);
    return 32'h0001_0000 * i;
  endfunction

  function automatic logic [31:0] pp(input int i);
    return 32'h2000_0000 + 32'h0010_0000 * i;
  endfunction

  initial begin
    #(20 * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit byp;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    for (int i = 0; i < 4; i++) probe("R1", 32'h0 + 32'h0123_4000 * i, 1'b0, '0);
    op(1'b0, '0, '0, '0, 1'b0, 1'b0, '0, byp);
    chk("R1 bypass", 64'(byp), 64'd0);

    // R4 round-robin from slot 0
    for (int i = 1; i <= 4; i++) fill(pv(i), pp(i), 2'd1);
    for (int i = 1; i <= 4; i++) probe("R4", pv(i) + 32'h0abc, 1'b1, pp(i) + 32'h0abc);
    fill(pv(5), pp(5), 2'd1);
    probe("R4 evict", pv(1), 1'b0, '0);
    probe("R4", pv(5) + 32'h10, 1'b1, pp(5) + 32'h10);
    // R5 overwrite in place, pointer unchanged
    fill(pv(2) + 32'h0200, 32'h3300_0000, 2'd1);
    probe("R5 new base", pv(2) + 32'h0456, 1'b1, 32'h3300_0456);
    fill(pv(6), pp(6), 2'd1);
    probe("R5 slot reuse", pv(2), 1'b0, '0);
    probe("R5", pv(3), 1'b1, pp(3));
    probe("R5", pv(4), 1'b1, pp(4));
    probe("R5", pv(6), 1'b1, pp(6));

    // R6 R7 lock lower two then flush
    set_lock(2);
    flush();
    probe("R6", pv(5), 1'b1, pp(5));
    probe("R6", pv(6), 1'b1, pp(6));
    probe("R7", pv(3), 1'b0, '0);
    probe("R7", pv(4), 1'b0, '0);
    // R4 wrap to lock base
    fill(pv(7), pp(7), 2'd1);
    fill(pv(8), pp(8), 2'd1);
    fill(pv(9), pp(9), 2'd1);
    probe("R4 wrap", pv(7), 1'b0, '0);
    probe("R4 wrap", pv(8), 1'b1, pp(8));
    probe("R4 wrap", pv(9), 1'b1, pp(9));
    probe("R6 locked kept", pv(5), 1'b1, pp(5));
    probe("R6 locked kept", pv(6), 1'b1, pp(6));
    // R8 invalidate
    inval(pv(5) + 32'h0321);
    probe("R6 inval locked", pv(5), 1'b1, pp(5));
    inval(pv(8) + 32'h0123);
    probe("R8", pv(8), 1'b0, '0);
    probe("R8", pv(9), 1'b1, pp(9));
    // R9 refill over locked entry dropped silently
    op(1'b1, pv(5), 32'h7700_0000, 2'd1, 1'b0, 1'b0, '0, byp);
    chk("R9 locked overlap bypass", 64'(byp), 64'd0);
    probe("R9 locked unchanged", pv(5) + 32'h44, 1'b1, pp(5) + 32'h44);
    // R9 all locked
    set_lock(4);
    op(1'b1, pv(10), pp(10), 2'd1, 1'b0, 1'b0, '0, byp);
    chk("R9 bypass", 64'(byp), 64'd1);
    probe("R9 dropped", pv(10), 1'b0, '0);
    flush();
    probe("R6 all locked", pv(5), 1'b1, pp(5));
    probe("R6 all locked", pv(6), 1'b1, pp(6));
    probe("R6 all locked", pv(9), 1'b1, pp(9));
    set_lock(0);
    flush();
    probe("R7 unlocked", pv(5), 1'b0, '0);
    probe("R7 unlocked", pv(9), 1'b0, '0);

    // R10 same-cycle clears and refill
    fill(pv(11), pp(11), 2'd1);
    fill(pv(12), pp(12), 2'd1);
    op(1'b1, pv(13), pp(13), 2'd1, 1'b1, 1'b0, '0, byp);
    probe("R10 flush+fill", pv(13), 1'b1, pp(13));
    probe("R10 flush+fill", pv(11), 1'b0, '0);
    probe("R10 flush+fill", pv(12), 1'b0, '0);
    op(1'b1, pv(13), 32'h5a00_0000, 2'd1, 1'b0, 1'b1, pv(13), byp);
    probe("R10 inval+fill", pv(13) + 32'h0f0, 1'b1, 32'h5a00_00f0);

    // R3 sweep over all sizes
    for (int s = 0; s < 4; s++) begin
      logic [31:0] base, pg, fva, fpa;
      flush();
      pg   = 32'h1 << (10 + (s == 0 ? 0 : s == 1 ? 2 : s == 2 ? 6 : 10));
      base = 32'h0A00_0000 + (32'(s) << 20);
      fva  = base | ((pg - 1) & 32'h0000_AAAA);
      fpa  = 32'h9ABC_DE00 + 32'(s) * 32'h0100_0000;
      fill(fva, fpa, 2'(s));
      for (int j = 0; j < 8; j++) begin
        logic [31:0] va;
        va = base + 32'(j) * (pg >> 3) + 32'(j * 3);
        probe("R3", va, 1'b1, xpa(va, fpa, 2'(s)));
      end
      probe("R3 above", base + pg, 1'b0, '0);
      probe("R3 below", base - 1, 1'b0, '0);
    end

    // R2 R5 mixed sizes and coarse overlap
    flush();
    fill(32'h0030_0000, 32'h4000_0000, 2'd3);
    fill(32'h0050_0400, 32'h5555_5400, 2'd0);
    probe("R2 section", 32'h003A_BCDE, 1'b1, 32'h400A_BCDE);
    @(negedge clk_i);
    lk_valid_i = 1'b1; lk_va_i = 32'h0031_0000;
    #2;
    chk("R2 size", 64'(lk_size_o), 64'd3);
    chk("R2 dom", 64'(lk_dom_o), 64'h3);
    chk("R2 ap", 64'(lk_ap_o), 64'h40);
    chk("R2 attr", 64'(lk_attr_o), 64'h3);
    lk_valid_i = 1'b0;
    #1 chk("R2 no request", 64'(lk_hit_o), 64'd0);
    probe("R2 tiny", 32'h0050_07FF, 1'b1, 32'h5555_57FF);
    probe("R2 tiny edge", 32'h0050_0800, 1'b0, '0);
    fill(32'h0030_1000, 32'h7000_1000, 2'd1);
    probe("R5 coarse overlap", 32'h0030_1ABC, 1'b1, 32'h7000_1ABC);
    probe("R5 coarse overlap", 32'h0030_5000, 1'b0, '0);
    probe("R5 other kept", 32'h0050_0400, 1'b1, 32'h5555_5400);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule